// File: doc/BRIEF.md
# Programmable Decimating FIR Filter with Stepped Gain

This block is the last filtering stage of a receive decimation chain. It takes complex baseband samples as parallel I and Q words qualified by a valid strobe. It runs both words through one FIR filter whose coefficients software loads. The filter output is decimated by 1, 2 or 4, scaled in 6 dB steps, rounded and saturated, and it leaves with its own valid strobe. At run time the filter can use 24, 48 or 72 taps. A bypass setting routes the input to the output unchanged.

Coefficients are loaded through an address/data write port into a staging bank. An active bank feeds the arithmetic. The staging bank is copied to the active bank on every cycle while the filter is disabled. While the filter is running, the copy waits until the next output sample has been computed. As a result, no output is ever produced from a mix of old and new coefficients.

Top module: `prog_dec_fir`

## Requirements
- R1: During reset and after its release, out_valid_o is 0 and out_i_o and out_q_o are 0.
- R2: When bypass_i is 1, every input strobe produces an output strobe one cycle later. That output carries in_i_i and in_q_i unchanged, whatever en_i, the coefficients and gain_sel_i are. The filter history and decimation phase are cleared.
- R3: When bypass_i is 0 and en_i is 0, no output strobe is produced. The sample history and decimation phase are cleared, so that the first sample after enabling starts from an all-zero history.
- R4: In filter mode, each output is y = sum over k < N of c[k]*x[n-k]. Here x[n] is the sample accepted in the output's triggering cycle, c[k] is the signed Q1.15 coefficient at write address k, and samples from before the enable count as zero. The output strobe follows the triggering input strobe by one cycle.
- R5: tap_sel_i selects N: code 0 gives 24 taps, code 1 gives 48 taps, and codes 2 and 3 give 72 taps. Coefficients at addresses N and above do not contribute.
- R6: dec_sel_i selects D: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4. After enabling, an output is produced on every D-th accepted input sample, and never without an input strobe one cycle earlier.
- R7: gain_sel_i scales the sum before rounding: code 0 is x2 (+6 dB), code 1 is x1, code 2 is x1/2 and code 3 is x1/4. The result is the scaled value rounded to the nearest integer, with ties toward plus infinity.
- R8: Results outside the signed 16-bit range are clamped to 32767 or -32768.
- R9: The I and Q paths use the same coefficients and share one output strobe. The output words hold their values between strobes.
- R10: A coefficient write made while the filter is enabled does not affect the next output. It takes effect from the output after that.
- R11: A coefficient write made while the filter is disabled takes effect within two cycles. A write to an address of 72 or more changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Filter enable; low clears history and opens coefficient update |
| bypass_i | input | 1 | Pass input straight to output |
| tap_sel_i | input | 2 | Tap count code |
| dec_sel_i | input | 2 | Decimation factor code |
| gain_sel_i | input | 2 | Output gain code |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 7 | Coefficient index |
| cfg_data_i | input | 16 | Coefficient value, signed Q1.15 |
| in_valid_i | input | 1 | Input sample strobe |
| in_i_i | input | 16 | In-phase input sample, signed |
| in_q_i | input | 16 | Quadrature input sample, signed |
| out_valid_o | output | 1 | Output sample strobe |
| out_i_o | output | 16 | In-phase output sample, signed |
| out_q_o | output | 16 | Quadrature output sample, signed |

## Verification
The hardest case to reach is a coefficient write that lands between two output samples of a running filter, because the change must stay invisible for exactly one more output. The bench enables the filter with decimation by 2 and waits for one output. While the next output is half accumulated, it writes a coefficient that sits inside the active tap range. It then checks the next two outputs against a reference model that holds the write in a pending stage until an output is emitted. Full-scale saturation in both directions is reached by loading every coefficient at its maximum positive value under +6 dB gain.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
  typedef enum logic [1:0] {
    GAIN_UP6  = 2'd0,
    GAIN_UNIT = 2'd1,
    GAIN_DN6  = 2'd2,
    GAIN_DN12 = 2'd3
  } gain_e;

  typedef enum logic [1:0] {
    DEC_BY1  = 2'd0,
    DEC_BY2  = 2'd1,
    DEC_BY4  = 2'd2,
    DEC_BY4X = 2'd3
  } dec_e;

  typedef enum logic [1:0] {
    TAPS_1X  = 2'd0,
    TAPS_2X  = 2'd1,
    TAPS_3X  = 2'd2,
    TAPS_3XB = 2'd3
  } taps_e;
endpackage

// File: rtl/dfir_coef_bank.sv
module dfir_coef_bank #(
  parameter int unsigned CW     = 16,
  parameter int unsigned NTAPS  = 72,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        emit_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [CW-1:0]               data_i,
  output logic [NTAPS-1:0][CW-1:0]    coef_o
);
  logic [NTAPS-1:0][CW-1:0] stg_q, act_q;
  logic pend_q;
  logic hit, copy;

  assign hit  = we_i && (int'(addr_i) < NTAPS);
  // swap only when idle or right after an output has used the old set
  assign copy = !en_i || (pend_q && emit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hit) stg_q[addr_i] <= data_i;
      if (copy) act_q <= stg_q;
      pend_q <= hit || (pend_q && !copy);
    end
  end

  assign coef_o = act_q;
endmodule

// File: rtl/dfir_delay_line.sv
module dfir_delay_line #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NTAPS = 72
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     shift_i,
  input  logic [DW-1:0]            din_i,
  output logic [NTAPS-1:0][DW-1:0] win_o
);
  logic [NTAPS-2:0][DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clr_i)   q <= '0;
    else if (shift_i) q <= {q[NTAPS-3:0], din_i};
  end

  // window index 0 is the sample arriving this cycle
  always_comb begin
    win_o[0] = din_i;
    for (int k = 1; k < NTAPS; k++) win_o[k] = q[k-1];
  end
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned NTAPS = 72,
  parameter int unsigned ACC_W = 39,
  parameter int unsigned CNT_W = 7
) (
  input  logic [NTAPS-1:0][DW-1:0] win_i,
  input  logic [NTAPS-1:0][CW-1:0] coef_i,
  input  logic [CNT_W-1:0]         ntaps_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [ACC_W-1:0] prod [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [ACC_W-1:0] xs, cs;
    assign xs = ACC_W'($signed(win_i[k]));
    assign cs = ACC_W'($signed(coef_i[k]));
    assign prod[k] = (CNT_W'(k) < ntaps_i) ? xs * cs : '0;
  end

  always_comb begin
    acc_o = '0;
    for (int k = 0; k < NTAPS; k++) acc_o = acc_o + prod[k];
  end
endmodule

// File: rtl/dfir_scale.sv
module dfir_scale
  import dfir_pkg::*;
#(
  parameter int unsigned ACC_W = 39,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [1:0]              gain_i,
  output logic signed [DW-1:0]    y_o
);
  localparam int unsigned W = ACC_W + 1;
  localparam logic signed [W-1:0] MAXV = (W'(1) <<< (DW-1)) - W'(1);
  localparam logic signed [W-1:0] MINV = -MAXV - W'(1);

  logic signed [W-1:0] ext, r;
  int sh;

  always_comb begin
    unique case (gain_e'(gain_i))
      GAIN_UP6:  sh = CW - 2;
      GAIN_UNIT: sh = CW - 1;
      GAIN_DN6:  sh = CW;
      default:   sh = CW + 1;
    endcase
    ext = W'(acc_i);
    r   = (ext + ($signed(W'(1)) <<< (sh - 1))) >>> sh;
    if (r > MAXV)      y_o = MAXV[DW-1:0];
    else if (r < MINV) y_o = MINV[DW-1:0];
    else               y_o = r[DW-1:0];
  end
endmodule

// File: rtl/prog_dec_fir.sv
module prog_dec_fir
  import dfir_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned TAP_STEP = 24
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic                                bypass_i,
  input  logic [1:0]                          tap_sel_i,
  input  logic [1:0]                          dec_sel_i,
  input  logic [1:0]                          gain_sel_i,
  input  logic                                cfg_we_i,
  input  logic [$clog2(3*TAP_STEP)-1:0]       cfg_addr_i,
  input  logic [COEF_W-1:0]                   cfg_data_i,
  input  logic                                in_valid_i,
  input  logic signed [DATA_W-1:0]            in_i_i,
  input  logic signed [DATA_W-1:0]            in_q_i,
  output logic                                out_valid_o,
  output logic signed [DATA_W-1:0]            out_i_o,
  output logic signed [DATA_W-1:0]            out_q_o
);
  localparam int unsigned MAX_TAPS = 3 * TAP_STEP;
  localparam int unsigned ADDR_W   = $clog2(MAX_TAPS);
  localparam int unsigned CNT_W    = $clog2(MAX_TAPS + 1);
  localparam int unsigned ACC_W    = DATA_W + COEF_W + $clog2(MAX_TAPS);

  logic [CNT_W-1:0] ntaps;
  logic [1:0]       dec_last, phase_q;
  logic             accept, emit, clr;
  logic [MAX_TAPS-1:0][COEF_W-1:0] coef;
  logic [DATA_W-1:0]               din [2];
  logic signed [DATA_W-1:0]        y   [2];

  always_comb begin
    unique case (taps_e'(tap_sel_i))
      TAPS_1X: ntaps = CNT_W'(TAP_STEP);
      TAPS_2X: ntaps = CNT_W'(2 * TAP_STEP);
      default: ntaps = CNT_W'(MAX_TAPS);
    endcase
    unique case (dec_e'(dec_sel_i))
      DEC_BY1: dec_last = 2'd0;
      DEC_BY2: dec_last = 2'd1;
      default: dec_last = 2'd3;
    endcase
  end

  assign accept = in_valid_i && en_i && !bypass_i;
  // >= keeps a factor change mid-stream from skipping a wrap
  assign emit   = accept && (phase_q >= dec_last);
  assign clr    = !en_i || bypass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr)    phase_q <= '0;
    else if (accept) phase_q <= emit ? 2'd0 : phase_q + 2'd1;
  end

  dfir_coef_bank #(
    .CW(COEF_W), .NTAPS(MAX_TAPS), .ADDR_W(ADDR_W)
  ) i_coef_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .emit_i (emit),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .coef_o (coef)
  );

  assign din[0] = in_i_i;
  assign din[1] = in_q_i;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [MAX_TAPS-1:0][DATA_W-1:0] win;
    logic signed [ACC_W-1:0]         acc;

    dfir_delay_line #(
      .DW(DATA_W), .NTAPS(MAX_TAPS)
    ) i_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .shift_i (accept),
      .din_i   (din[p]),
      .win_o   (win)
    );

    dfir_mac #(
      .DW(DATA_W), .CW(COEF_W), .NTAPS(MAX_TAPS), .ACC_W(ACC_W), .CNT_W(CNT_W)
    ) i_mac (
      .win_i   (win),
      .coef_i  (coef),
      .ntaps_i (ntaps),
      .acc_o   (acc)
    );

    dfir_scale #(
      .ACC_W(ACC_W), .DW(DATA_W), .CW(COEF_W)
    ) i_scale (
      .acc_i  (acc),
      .gain_i (gain_sel_i),
      .y_o    (y[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_i_o     <= '0;
      out_q_o     <= '0;
    end else begin
      out_valid_o <= bypass_i ? in_valid_i : emit;
      if (bypass_i && in_valid_i) begin
        out_i_o <= in_i_i;
        out_q_o <= in_q_i;
      end else if (emit) begin
        out_i_o <= y[0];
        out_q_o <= y[1];
      end
    end
  end
endmodule

// File: rtl/dfir_checker.sv
module dfir_checker #(
  parameter int unsigned DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 bypass_i,
  input logic [1:0]           dec_sel_i,
  input logic                 in_valid_i,
  input logic signed [DW-1:0] in_i_i,
  input logic signed [DW-1:0] in_q_i,
  input logic                 out_valid_o,
  input logic signed [DW-1:0] out_i_o,
  input logic signed [DW-1:0] out_q_o
);
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && in_valid_i) |=> (out_valid_o && out_i_o == $past(in_i_i) && out_q_o == $past(in_q_i))); // R2

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !bypass_i) |=> !out_valid_o); // R3

  AST_NO_OUT_WITHOUT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R6

  AST_DEC1_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && dec_sel_i == 2'd0 && in_valid_i) |=> out_valid_o); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(out_i_o) && $stable(out_q_o))); // R9
endmodule

bind prog_dec_fir dfir_checker #(.DW(DATA_W)) i_dfir_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .bypass_i    (bypass_i),
  .dec_sel_i   (dec_sel_i),
  .in_valid_i  (in_valid_i),
  .in_i_i      (in_i_i),
  .in_q_i      (in_q_i),
  .out_valid_o (out_valid_o),
  .out_i_o     (out_i_o),
  .out_q_o     (out_q_o)
);

// File: tb/test_prog_dec_fir.sv
module test_prog_dec_fir;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 72;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, bypass = 1'b0, we = 1'b0, in_valid = 1'b0;
  logic [1:0] tap_sel = '0, dec_sel = '0, gain_sel = '0;
  logic [6:0] addr = '0;
  logic [15:0] data = '0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_dec_fir i_prog_dec_fir (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .bypass_i(bypass),
    .tap_sel_i(tap_sel), .dec_sel_i(dec_sel), .gain_sel_i(gain_sel),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(data),
    .in_valid_i(in_valid), .in_i_i(in_i), .in_q_i(in_q),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  typedef struct packed {
    logic [1:0] tap;
    logic [1:0] dec;
    logic [1:0] gain;
    logic [7:0] n;
    logic [7:0] nout;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd0, 2'd1, 8'd30, 8'd30},
    '{2'd1, 2'd1, 2'd1, 8'd40, 8'd20},
    '{2'd2, 2'd2, 2'd0, 8'd50, 8'd12},
    '{2'd2, 2'd1, 2'd2, 8'd21, 8'd10},
    '{2'd0, 2'd3, 2'd3, 8'd17, 8'd4},
    '{2'd3, 2'd0, 2'd3, 8'd12, 8'd12}
  };

  int n_chk = 0, n_fail = 0, n_out = 0;
  bit done = 1'b0;
  bit [31:0] seed = 32'h1234_5678;

  int m_stg [NT], m_act [NT], h_i [NT], h_q [NT];
  int m_phase = 0;
  bit m_pend = 1'b0;
  longint last_i = 0, last_q = 0;

  task automatic chk(string tag, longint a, longint e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  function automatic int rnd(int span);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[30:12] % span) - span / 2;
  endfunction

  function automatic longint fir_out(bit q_path);
    longint acc = 0;
    int n, sh;
    longint y;
    n  = (tap_sel == 2'd0) ? 24 : (tap_sel == 2'd1) ? 48 : 72;
    sh = 14 + int'(gain_sel);
    for (int k = 0; k < n; k++)
      acc += longint'(q_path ? h_q[k] : h_i[k]) * longint'(m_act[k]);
    y = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < NT; k++) begin h_i[k] = 0; h_q[k] = 0; end
    m_phase = 0;
  endfunction

  task automatic send(int xi, int xq, string tag);
    bit ev;
    longint ei, eq;
    int d;
    ev = 1'b0; ei = last_i; eq = last_q;
    d = (dec_sel == 2'd0) ? 1 : (dec_sel == 2'd1) ? 2 : 4;
    if (!en) begin
      for (int k = 0; k < NT; k++) m_act[k] = m_stg[k];
      m_pend = 1'b0;
    end
    if (bypass) begin
      ev = 1'b1; ei = xi; eq = xq;
      model_clear();
    end else if (en) begin
      for (int k = NT - 1; k > 0; k--) begin h_i[k] = h_i[k-1]; h_q[k] = h_q[k-1]; end
      h_i[0] = xi; h_q[0] = xq;
      m_phase++;
      if (m_phase >= d) begin
        ev = 1'b1; ei = fir_out(1'b0); eq = fir_out(1'b1);
        m_phase = 0;
        if (m_pend) begin
          for (int k = 0; k < NT; k++) m_act[k] = m_stg[k];
          m_pend = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, longint'(out_valid), longint'(ev));
    chk({tag, " I"}, longint'(out_i), ei);
    chk({tag, " Q"}, longint'(out_q), eq);
    if (out_valid) n_out++;
    last_i = ei; last_q = eq;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 7'(a); data = 16'(d);
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    if (a < NT) begin
      m_stg[a] = int'($signed(16'(d)));
      if (!en) m_act[a] = m_stg[a];
      else m_pend = 1'b1;
    end
  endtask

  task automatic set_cfg(logic [1:0] t, logic [1:0] dc, logic [1:0] g);
    @(negedge clk);
    en = 1'b0; bypass = 1'b0; tap_sel = t; dec_sel = dc; gain_sel = g;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NT; k++) m_act[k] = m_stg[k];
    m_pend = 1'b0;
    model_clear();
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) begin m_stg[k] = 0; m_act[k] = 0; end
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", longint'(out_valid), 0);
    chk("R1 I in reset", longint'(out_i), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", longint'(out_valid), 0);
    chk("R1 Q after reset", longint'(out_q), 0);

    // R11: load while disabled, plus an out-of-range address
    for (int a = 0; a < NT; a++) wr(a, rnd(8192));
    wr(100, 12345);

    // R2: bypass, both with filter disabled and enabled
    bypass = 1'b1;
    send(1234, -4321, "R2");
    send(-32768, 32767, "R2");
    en = 1'b1;
    send(77, -78, "R2");
    bypass = 1'b0; en = 1'b0;
    // R3: disabled, no output and held values
    send(500, 600, "R3");
    send(-500, -600, "R3");

    // main table
    for (int v = 0; v < 6; v++) begin
      set_cfg(VECS[v].tap, VECS[v].dec, VECS[v].gain);
      n_out = 0;
      for (int s = 0; s < int'(VECS[v].n); s++)
        send(rnd(30000), rnd(30000), "R4 R5 R6 R7 R9 R11");
      chk("R6 output count", n_out, longint'(VECS[v].nout));
    end

    // R10: write lands between two outputs of a running filter
    set_cfg(2'd0, 2'd1, 2'd1);
    send(9000, -7000, "R10");
    send(8000, 6000, "R10");
    send(-3000, 2500, "R10");
    wr(0, 30000);
    send(12000, -11000, "R10 old set");
    send(4000, 3000, "R10");
    send(-9000, 7000, "R10 new set");

    // R7: rounding with a unit impulse response
    for (int a = 0; a < NT; a++) wr(a, 0);
    wr(0, 1);
    set_cfg(2'd0, 2'd0, 2'd1);
    send(16384, 16383, "R7");
    chk("R7 tie up", longint'(out_i), 1);
    chk("R7 below half", longint'(out_q), 0);
    send(-16384, -16385, "R7");
    chk("R7 negative tie", longint'(out_i), 0);
    chk("R7 negative past half", longint'(out_q), -1);
    set_cfg(2'd0, 2'd0, 2'd0);
    send(8192, -8193, "R7 gain +6");
    chk("R7 gain +6", longint'(out_i), 1);

    // R8: full-scale saturation
    for (int a = 0; a < NT; a++) wr(a, 32767);
    set_cfg(2'd2, 2'd0, 2'd0);
    send(32767, -32768, "R8");
    chk("R8 clamp high", longint'(out_i), 32767);
    chk("R8 clamp low", longint'(out_q), -32768);
    send(32767, -32768, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule